// File: doc/BRIEF.md
# Counted FIFO Transfer Controller

This block moves a programmed number of bytes through a 512-byte FIFO that sits between a host-side stream and a device-side stream. One 32-bit control word holds the byte count, the direction, the beat width and a start bit. In the write direction the host fills the FIFO and the device drains it. In the read direction the device fills it and the host drains it. In 16-bit mode a beat carries two bytes. The final odd byte of a count travels alone.

While a run is active the block pulses a chunk event each time a whole 512-byte chunk is ready. In the read direction that is a chunk of data ready for the host. In the write direction it is a chunk of space the host may fill. A long count is therefore served as repeated FIFO refills. A completion event marks the point where the last byte has left the FIFO. The start bit clears itself when a run completes, when software writes the control word with start clear, and when the device reports an error through the error input. In the error case an error event is pulsed. Every control write resets the FIFO pointers.

Top module: `xfer_fifo_ctrl`

## Requirements
- R1: After reset the control readback is zero, every ready and valid output is low and no event is pulsed.
- R2: Control word layout: bits 17:0 byte count, bit 24 address-increment disable, bit 25 16-bit beats, bit 28 DMA mode, bit 30 direction (1 = host to device, 0 = device to host), bit 31 start. These fields read back unchanged and all other bits read as zero. Bit 31 reads 1 only while a run is active.
- R3: With bit 30 set, bytes taken on the host input leave on the device output in the same order. A 16-bit beat carries the earlier byte in bits 7:0 and the later byte in bits 15:8. A lone final byte sits in bits 7:0 with bits 15:8 zero. The device output data holds still while its valid is high and ready is low.
- R4: With bit 30 clear, bytes taken on the device input leave on the host output, with the same ordering and packing as R3.
- R5: In the read direction, the chunk event pulses for one cycle, in the cycle after a device-side push brings the pushed byte total to a nonzero multiple of 512.
- R6: In the write direction, the chunk event pulses in the cycle after a start whose count is at least 512. It also pulses in the cycle after a device-side pop brings the drained total to a multiple of 512, provided at least 512 bytes then remain.
- R7: The completion event pulses for one cycle, in the cycle after the last byte of the count leaves the FIFO, and bit 31 reads 0 in that cycle. A final chunk shorter than 512 bytes gives completion without a chunk event, so a run gives floor(count/512) chunk events in total.
- R8: A start with a count of zero pulses completion in the next cycle. Bit 31 then reads 0 and no ready or valid output rises.
- R9: A control write with bit 31 clear during a run stops the run at once: in the next cycle bit 31 is 0 and every ready and valid output is low, and no completion follows.
- R10: The error input, while a run is active, pulses the error event in the next cycle and stops the run without completion. While idle the error input has no effect.
- R11: The producer side stalls (ready low) once 512 bytes are buffered, until the consumer drains. A new start discards any leftover bytes, and the new run delivers only its own data.
- R12: A count of 0x20000 bytes completes in one run with 256 chunk events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_o | output | 32 | Control word readback with live start bit |
| err_i | input | 1 | Device transfer error |
| host_in_valid_i | input | 1 | Host data beat valid (write direction) |
| host_in_data_i | input | 16 | Host data beat |
| host_in_ready_o | output | 1 | FIFO accepts a host beat |
| host_out_valid_o | output | 1 | Beat available to host (read direction) |
| host_out_data_o | output | 16 | Beat to host |
| host_out_ready_i | input | 1 | Host takes the beat |
| dev_in_valid_i | input | 1 | Device data beat valid (read direction) |
| dev_in_data_i | input | 16 | Device data beat |
| dev_in_ready_o | output | 1 | FIFO accepts a device beat |
| dev_out_valid_o | output | 1 | Beat available to device (write direction) |
| dev_out_data_o | output | 16 | Beat to device |
| dev_out_ready_i | input | 1 | Device takes the beat |
| buf_avail_o | output | 1 | Chunk ready pulse |
| xfer_done_o | output | 1 | Completion pulse |
| xfer_err_o | output | 1 | Error pulse |

## Verification
The bench aims at chunk boundaries. A design that counted chunks from the fill level rather than from running totals would pulse late or twice when producer and consumer overlap. A design that announced the short final chunk would give one event too many. Odd counts in 16-bit mode check that the lone last byte is not padded with a stale byte and that no beat overruns the count. Zero counts, aborts with a full FIFO, an error in the middle of a run and the largest count probe the stop paths: a faulty design would hang with start still set, leak a completion after an abort, or hand leftover bytes to the next run.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int CNT_W   = 18;
  localparam int B_NOINC = 24;
  localparam int B_WIDE  = 25;
  localparam int B_DMA   = 28;
  localparam int B_WR    = 30;
  localparam int B_GO    = 31;

  typedef struct packed {
    logic             go;
    logic             wr;
    logic             dma;
    logic             wide;
    logic             noinc;
    logic [CNT_W-1:0] cnt;
  } xfer_cfg_t;
endpackage

// File: rtl/xfer_ctrl_reg.sv
module xfer_ctrl_reg
  import xfer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        finish_i,
  output xfer_cfg_t   cfg_o,
  output logic [31:0] rdata_o
);
  xfer_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.cnt   <= wdata_i[CNT_W-1:0];
      cfg_q.noinc <= wdata_i[B_NOINC];
      cfg_q.wide  <= wdata_i[B_WIDE];
      cfg_q.dma   <= wdata_i[B_DMA];
      cfg_q.wr    <= wdata_i[B_WR];
      // zero count finishes at launch, never goes active
      cfg_q.go    <= wdata_i[B_GO] && (wdata_i[CNT_W-1:0] != '0);
    end else if (finish_i) begin
      cfg_q.go <= 1'b0;
    end
  end

  always_comb begin
    rdata_o               = '0;
    rdata_o[CNT_W-1:0]    = cfg_q.cnt;
    rdata_o[B_NOINC]      = cfg_q.noinc;
    rdata_o[B_WIDE]       = cfg_q.wide;
    rdata_o[B_DMA]        = cfg_q.dma;
    rdata_o[B_WR]         = cfg_q.wr;
    rdata_o[B_GO]         = cfg_q.go;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          push_two_i,
  input  logic [15:0]   push_data_i,
  input  logic          pop_i,
  input  logic          pop_two_i,
  output logic [15:0]   pop_data_o,
  output logic [AW:0]   fill_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW-1:0] wr_p1, rd_p1;
  logic [AW:0]   fill_q;
  logic [AW:0]   push_n, pop_n;

  assign wr_p1  = wr_q + 1'b1;
  assign rd_p1  = rd_q + 1'b1;
  assign push_n = !push_i ? '0 : (push_two_i ? (AW+1)'(2) : (AW+1)'(1));
  assign pop_n  = !pop_i  ? '0 : (pop_two_i  ? (AW+1)'(2) : (AW+1)'(1));

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) begin
      mem[wr_q] <= push_data_i[7:0];
      if (push_two_i) mem[wr_p1] <= push_data_i[15:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_q + push_n[AW-1:0];
      rd_q   <= rd_q + pop_n[AW-1:0];
      fill_q <= fill_q + push_n - pop_n;
    end
  end

  assign pop_data_o = {pop_two_i ? mem[rd_p1] : 8'h00, mem[rd_q]};
  assign fill_o     = fill_q;
endmodule

// File: rtl/xfer_chunk_events.sv
module xfer_chunk_events
  import xfer_pkg::*;
#(
  parameter int CHUNK = 512,
  localparam int CW   = $clog2(CHUNK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             launch_go_i,
  input  logic             launch_wr_i,
  input  logic [CNT_W-1:0] launch_cnt_i,
  input  logic             active_i,
  input  logic             dir_wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             err_i,
  input  logic             push_i,
  input  logic             push_two_i,
  input  logic             pop_i,
  input  logic             pop_two_i,
  output logic [CNT_W-1:0] in_left_o,
  output logic [CNT_W-1:0] out_left_o,
  output logic             finish_o,
  output logic             buf_o,
  output logic             done_o,
  output logic             err_o
);
  logic [CNT_W-1:0] in_cnt_q, out_cnt_q, in_nxt, out_nxt, out_rest;
  logic             in_cross, out_cross, out_last, more_chunk;
  logic             buf_q, done_q, err_q;

  assign in_nxt     = in_cnt_q  + (push_two_i ? CNT_W'(2) : CNT_W'(1));
  assign out_nxt    = out_cnt_q + (pop_two_i  ? CNT_W'(2) : CNT_W'(1));
  assign in_left_o  = cnt_i - in_cnt_q;
  assign out_left_o = cnt_i - out_cnt_q;
  assign in_cross   = in_nxt[CNT_W-1:CW]  != in_cnt_q[CNT_W-1:CW];
  assign out_cross  = out_nxt[CNT_W-1:CW] != out_cnt_q[CNT_W-1:CW];
  assign out_last   = out_nxt == cnt_i;
  assign out_rest   = cnt_i - out_nxt;
  assign more_chunk = out_rest >= CNT_W'(CHUNK);
  // error wins over completion; a control write cancels both
  assign finish_o   = active_i && !launch_i && (err_i || (pop_i && out_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      buf_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      buf_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (launch_i) begin
        in_cnt_q  <= '0;
        out_cnt_q <= '0;
        if (launch_go_i) begin
          if (launch_cnt_i == '0) done_q <= 1'b1;
          else if (launch_wr_i && launch_cnt_i >= CNT_W'(CHUNK)) buf_q <= 1'b1;
        end
      end else if (active_i) begin
        if (err_i) begin
          err_q <= 1'b1;
        end else begin
          if (push_i) begin
            in_cnt_q <= in_nxt;
            if (!dir_wr_i && in_cross) buf_q <= 1'b1;
          end
          if (pop_i) begin
            out_cnt_q <= out_nxt;
            if (out_last) done_q <= 1'b1;
            else if (dir_wr_i && out_cross && more_chunk) buf_q <= 1'b1;
          end
        end
      end
    end
  end

  assign buf_o  = buf_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_o,
  input  logic        err_i,
  input  logic        host_in_valid_i,
  input  logic [15:0] host_in_data_i,
  output logic        host_in_ready_o,
  output logic        host_out_valid_o,
  output logic [15:0] host_out_data_o,
  input  logic        host_out_ready_i,
  input  logic        dev_in_valid_i,
  input  logic [15:0] dev_in_data_i,
  output logic        dev_in_ready_o,
  output logic        dev_out_valid_o,
  output logic [15:0] dev_out_data_o,
  input  logic        dev_out_ready_i,
  output logic        buf_avail_o,
  output logic        xfer_done_o,
  output logic        xfer_err_o
);
  localparam int          AW      = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  xfer_cfg_t        cfg;
  logic             finish;
  logic [CNT_W-1:0] in_left, out_left;
  logic [AW:0]      fill, free, need_in, need_out;
  logic             in_two, out_two, prod_rdy, cons_vld, push, pop;
  logic [15:0]      push_data, pop_data;

  xfer_ctrl_reg i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .finish_i(finish),
    .cfg_o   (cfg),
    .rdata_o (ctrl_o)
  );

  assign in_two   = cfg.wide && (in_left  >= CNT_W'(2));
  assign out_two  = cfg.wide && (out_left >= CNT_W'(2));
  assign need_in  = in_two  ? (AW+1)'(2) : (AW+1)'(1);
  assign need_out = out_two ? (AW+1)'(2) : (AW+1)'(1);
  assign free     = DEPTH_L - fill;
  assign prod_rdy = cfg.go && (in_left  != '0) && (free >= need_in);
  assign cons_vld = cfg.go && (out_left != '0) && (fill >= need_out);

  assign host_in_ready_o  = prod_rdy &&  cfg.wr;
  assign dev_in_ready_o   = prod_rdy && !cfg.wr;
  assign dev_out_valid_o  = cons_vld &&  cfg.wr;
  assign host_out_valid_o = cons_vld && !cfg.wr;
  assign dev_out_data_o   = pop_data;
  assign host_out_data_o  = pop_data;

  assign push      = cfg.wr ? (host_in_valid_i && host_in_ready_o)
                            : (dev_in_valid_i  && dev_in_ready_o);
  assign push_data = cfg.wr ? host_in_data_i : dev_in_data_i;
  assign pop       = cfg.wr ? (dev_out_valid_o  && dev_out_ready_i)
                            : (host_out_valid_o && host_out_ready_i);

  xfer_byte_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctrl_we_i),
    .push_i     (push),
    .push_two_i (in_two),
    .push_data_i(push_data),
    .pop_i      (pop),
    .pop_two_i  (out_two),
    .pop_data_o (pop_data),
    .fill_o     (fill)
  );

  xfer_chunk_events #(.CHUNK(DEPTH)) i_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (ctrl_we_i),
    .launch_go_i (ctrl_wdata_i[B_GO]),
    .launch_wr_i (ctrl_wdata_i[B_WR]),
    .launch_cnt_i(ctrl_wdata_i[CNT_W-1:0]),
    .active_i    (cfg.go),
    .dir_wr_i    (cfg.wr),
    .cnt_i       (cfg.cnt),
    .err_i       (err_i),
    .push_i      (push),
    .push_two_i  (in_two),
    .pop_i       (pop),
    .pop_two_i   (out_two),
    .in_left_o   (in_left),
    .out_left_o  (out_left),
    .finish_o    (finish),
    .buf_o       (buf_avail_o),
    .done_o      (xfer_done_o),
    .err_o       (xfer_err_o)
  );
endmodule

// File: rtl/xfer_fifo_ctrl_chk.sv
module xfer_fifo_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [31:0] ctrl_wdata_i,
  input logic [31:0] ctrl_o,
  input logic        err_i,
  input logic        host_in_ready_o,
  input logic        host_out_valid_o,
  input logic        dev_in_ready_o,
  input logic        dev_out_valid_o,
  input logic [15:0] dev_out_data_o,
  input logic        dev_out_ready_i,
  input logic        xfer_done_o,
  input logic        xfer_err_o
);
  localparam logic [31:0] FIELD_MASK = 32'h5303_FFFF;

  // R2
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o & 32'h7FFF_FFFF) == ($past(ctrl_wdata_i) & FIELD_MASK));
  // R3
  write_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[30] |-> (!dev_in_ready_o && !host_out_valid_o));
  // R4
  read_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[30] |-> (!host_in_ready_o && !dev_out_valid_o));
  // R3
  dev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_out_valid_o && !dev_out_ready_i && !ctrl_we_i && !err_i)
      |=> (dev_out_valid_o && $stable(dev_out_data_o)));
  // R7
  done_clears_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> !ctrl_o[31]);
  // R8
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[31] && ctrl_wdata_i[17:0] == 18'd0)
      |=> (xfer_done_o && !ctrl_o[31]));
  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_wdata_i[31]) |=> (!xfer_done_o && !ctrl_o[31]));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[31] |-> !(host_in_ready_o || dev_in_ready_o || host_out_valid_o || dev_out_valid_o));
  // R10
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |-> ($past(err_i) && !ctrl_o[31] && !xfer_done_o));
endmodule

bind xfer_fifo_ctrl xfer_fifo_ctrl_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ctrl_we_i       (ctrl_we_i),
  .ctrl_wdata_i    (ctrl_wdata_i),
  .ctrl_o          (ctrl_o),
  .err_i           (err_i),
  .host_in_ready_o (host_in_ready_o),
  .host_out_valid_o(host_out_valid_o),
  .dev_in_ready_o  (dev_in_ready_o),
  .dev_out_valid_o (dev_out_valid_o),
  .dev_out_data_o  (dev_out_data_o),
  .dev_out_ready_i (dev_out_ready_i),
  .xfer_done_o     (xfer_done_o),
  .xfer_err_o      (xfer_err_o)
);

// File: tb/test_xfer_fifo_ctrl.sv
module test_xfer_fifo_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_o;
  logic        err_i = 1'b0;
  logic        host_in_valid_i = 1'b0;
  logic [15:0] host_in_data_i = '0;
  logic        host_in_ready_o;
  logic        host_out_valid_o;
  logic [15:0] host_out_data_o;
  logic        host_out_ready_i = 1'b0;
  logic        dev_in_valid_i = 1'b0;
  logic [15:0] dev_in_data_i = '0;
  logic        dev_in_ready_o;
  logic        dev_out_valid_o;
  logic [15:0] dev_out_data_o;
  logic        dev_out_ready_i = 1'b0;
  logic        buf_avail_o, xfer_done_o, xfer_err_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  xfer_fifo_ctrl i_xfer_fifo_ctrl (.*);

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 195000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<195000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((i * 37) ^ (s * 91) ^ (i >> 7));
  endfunction

  function automatic logic [31:0] cword(input bit go, input bit wr, input bit wide, input int cnt);
    return {go, wr, 4'b0, wide, 7'b0, 18'(cnt)};
  endfunction

  task automatic write_ctrl(input logic [31:0] w);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = w;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic idle_drive();
    host_in_valid_i = 0; dev_in_valid_i = 0; host_out_ready_i = 0;
    dev_out_ready_i = 0; err_i = 0;
  endtask

  // full run with a reference model; err_at >= 0 injects an error after that many bytes drained
  task automatic run_xfer(input bit wr, input bit wide, input int cnt, input int stall,
                          input int s, input int err_at, input string req);
    int sent = 0, got = 0, bufs = 0, dones = 0, errs = 0, ev_bad = 0, data_bad = 0;
    int pn, qn, cyc = 0;
    bit pv = 0, pn2 = 0, cr, take, pop, finished = 0, err_sent = 0, start_ok = 1;
    bit exp_buf, exp_done, exp_err = 0;
    logic [15:0] pd = '0, cdat, cexp = '0, bad_act = '0, bad_exp = '0;
    write_ctrl(cword(1'b1, wr, wide, cnt));
    exp_done = (cnt == 0);
    exp_buf  = wr && cnt >= 512;
    while (!finished && cyc < 150000) begin
      cyc++;
      if (buf_avail_o !== exp_buf || xfer_done_o !== exp_done || xfer_err_o !== exp_err) ev_bad++;
      bufs += int'(buf_avail_o); dones += int'(xfer_done_o); errs += int'(xfer_err_o);
      if (xfer_done_o || xfer_err_o) begin
        finished = 1;
        if (ctrl_o[31] || host_in_ready_o || dev_in_ready_o || host_out_valid_o || dev_out_valid_o)
          start_ok = 0;
      end else begin
        if (!pv && sent < cnt && $urandom_range(99) >= stall) begin
          pn2 = wide && (cnt - sent >= 2);
          pd  = {pn2 ? pat(s, sent + 1) : 8'h00, pat(s, sent)};
          pv  = 1;
        end
        host_in_valid_i = pv && wr;  host_in_data_i = pd;
        dev_in_valid_i  = pv && !wr; dev_in_data_i  = pd;
        cr = $urandom_range(99) >= stall;
        host_out_ready_i = cr && !wr;
        dev_out_ready_i  = cr && wr;
        if (err_at >= 0 && !err_sent && got >= err_at) begin err_i = 1; err_sent = 1; end
        else err_i = 0;
        #1;
        take = pv && (wr ? host_in_ready_o : dev_in_ready_o);
        pop  = cr && (wr ? dev_out_valid_o : host_out_valid_o);
        cdat = wr ? dev_out_data_o : host_out_data_o;
        qn   = (wide && cnt - got >= 2) ? 2 : 1;
        pn   = take ? (pn2 ? 2 : 1) : 0;
        if (pop) begin
          cexp = {qn == 2 ? pat(s, got + 1) : 8'h00, pat(s, got)};
          if (cdat !== cexp) begin
            if (data_bad == 0) begin bad_act = cdat; bad_exp = cexp; end
            data_bad++;
          end
        end
        if (err_i) begin
          exp_err = 1; exp_buf = 0; exp_done = 0;
        end else begin
          exp_err  = 0;
          exp_buf  = (!wr && take && ((sent + pn) % 512 == 0)) ||
                     (wr && pop && ((got + qn) % 512 == 0) && (cnt - (got + qn) >= 512));
          exp_done = pop && (got + qn == cnt);
        end
        if (take) begin sent += pn; pv = 0; end
        if (pop) got += qn;
        @(negedge clk_i);
      end
    end
    idle_drive();
    check(finished, {req, " run ends"}, finished, 1);
    check(ev_bad == 0, {req, " event timing R5 R6 R7 R10"}, ev_bad, 0);
    check(data_bad == 0, {req, " data order R3 R4"}, bad_act, bad_exp);
    check(start_ok, {req, " start clear and quiet at end R7"}, ctrl_o, 0);
    if (err_at < 0) begin
      check(dones == 1 && got == cnt, {req, " completion count R7"}, got, cnt);
      check(bufs == cnt / 512, {req, " chunk events R5 R6 R7"}, bufs, cnt / 512);
    end else begin
      check(errs == 1 && dones == 0, {req, " error stop R10"}, dones, 0);
    end
  endtask

  initial begin
    int acc;
    bit saw_done;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(ctrl_o == 0, "R1 ctrl reset", ctrl_o, 0);
    check(!(host_in_ready_o || dev_in_ready_o || host_out_valid_o || dev_out_valid_o ||
            buf_avail_o || xfer_done_o || xfer_err_o), "R1 outputs idle", 1, 0);

    // R2: fields kept, others zero, start 0
    write_ctrl(32'h7FFF_0155);
    check(ctrl_o == 32'h5303_0155, "R2 readback", ctrl_o, 32'h5303_0155);

    // R8: zero count
    run_xfer(1'b1, 1'b0, 0, 0, 1, -1, "R8 zero count");

    run_xfer(1'b1, 1'b0, 700, 30, 2, -1, "R3 R6 write 8b");
    run_xfer(1'b0, 1'b0, 1024, 30, 3, -1, "R4 R5 read 8b");
    run_xfer(1'b1, 1'b1, 1025, 20, 4, -1, "R3 write 16b odd");
    run_xfer(1'b0, 1'b1, 513, 20, 5, -1, "R4 R5 R7 read 16b partial");

    // R11: producer stalls at 512 buffered
    write_ctrl(cword(1'b1, 1'b1, 1'b0, 1000));
    acc = 0;
    for (int i = 0; i < 600; i++) begin
      host_in_valid_i = 1; host_in_data_i = {8'h00, pat(9, acc)};
      #1;
      if (host_in_ready_o) acc++;
      @(negedge clk_i);
    end
    host_in_valid_i = 0;
    check(acc == 512, "R11 capacity", acc, 512);
    check(!host_in_ready_o, "R11 stall ready low", host_in_ready_o, 0);

    // R9: abort with full FIFO
    write_ctrl(32'h0);
    check(!(ctrl_o[31] || host_in_ready_o || dev_out_valid_o), "R9 abort stops", ctrl_o, 0);
    saw_done = 0;
    for (int i = 0; i < 5; i++) begin
      if (xfer_done_o || buf_avail_o) saw_done = 1;
      @(negedge clk_i);
    end
    check(!saw_done, "R9 no completion after abort", saw_done, 0);

    // R11: restart delivers only fresh data
    run_xfer(1'b0, 1'b0, 100, 10, 11, -1, "R11 restart");

    // R10: error mid run, then error while idle
    run_xfer(1'b0, 1'b1, 600, 20, 12, 200, "R10 error");
    err_i = 1;
    @(negedge clk_i);
    err_i = 0;
    check(!xfer_err_o && !ctrl_o[31], "R10 idle error ignored", xfer_err_o, 0);

    for (int k = 0; k < 6; k++) begin
      int c;
      c = $urandom_range(1500, 1);
      run_xfer(1'($urandom_range(1)), 1'($urandom_range(1)), c, $urandom_range(40), 20 + k, -1,
               "R3 R4 R5 R6 random");
    end

    // R12: largest count
    run_xfer(1'b1, 1'b1, 32'h20000, 0, 30, -1, "R12 max count");

    summary();
  end
endmodule